// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Baud Generator

This block moves bytes over a three-wire clocked serial link: a data output, a data input and a shift clock. A small register interface lets a host set the clock mode, load a divider value, write a byte to send and read back the byte that arrived. Every shift exchanges one outgoing bit for one incoming bit, so a single transfer is full duplex. Half-duplex use simply ignores one direction.

When the port is the clock master, the shift clock comes from a free-standing rate generator. A selectable prescaler (divide by 4 or by 16) drives an 8-bit reloadable counter that divides by n+1. Each shift-clock half period lasts two of that counter's ticks. A transfer makes exactly eight clock pulses and then parks the clock high. When the port is the slave, the clock pin is an input. The block synchronizes it, detects its edges and shifts on each one for as long as edges keep coming, counting groups of eight. Data leaves least-significant bit first. It changes on falling clock edges and is sampled on rising ones.

Register map (addr): 0 = control (write bit0 prescale-16, bit1 slave clock, bit2 send enable; read adds bit6 busy and bit7 complete), 1 = divider reload n, 2 = write: send byte / read: received byte.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, control reads 0x00, sck_out is 1, sck_oe is 1 and the complete flag (control bit7) is clear.
- R2: In master mode (control bit1=0), writing addr 2 while send enable (control bit2) is 1 gives exactly 8 falling edges on sck_out, after which sck_out stays at 1.
- R3: In master mode the low time of sck_out is 2*P*(n+1) clock cycles, where P is 4 when control bit0=0 and 16 when it is 1, and n is the value in addr 1.
- R4: Before the k-th rising edge of the shift clock (k = 1..8), sdo carries bit k-1 of the byte written to addr 2, so the byte leaves least-significant bit first.
- R5: sdi is sampled on each rising shift-clock edge, least-significant bit first. After the 8th sample, addr 2 reads the assembled byte and control bit7 reads 1.
- R6: A read of addr 2 clears control bit7.
- R7: A write to addr 2 while send enable is 0 is ignored. No shift-clock edge appears and control bit7 stays 0.
- R8: In slave mode (control bit1=1), sck_oe is 0, and the port shifts on the synchronized edges of sck_in: sdo changes after falling edges and sdi is sampled on rising edges.
- R9: In slave mode shifting does not stop after 8 edges. A second group of 8 clocks sets control bit7 again, and during it sdo sends out the byte received in the first group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of addr 2 clears the complete flag) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sck_in | input | 1 | Shift clock from the pin (slave mode) |
| sck_out | output | 1 | Shift clock driven to the pin (master mode) |
| sck_oe | output | 1 | Drive enable for the clock pin, 1 in master mode |

## Verification
A wrong divider or prescaler state shows up as a wrong sck_out low width on the very first falling edge, within 2*P*(n+1) cycles of the start. A wrong bit counter shows as a ninth or a missing eighth pulse, or as a complete flag that rises too early. A shift-register fault corrupts sdo at the next rising edge, or the received byte at the end of the frame. A broken edge detector in slave mode shows within about three cycles of a bench-driven clock edge, as an sdo that does not move or a missing sample.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic send_en;
        logic slave;
        logic pre16;
    } ssp_ctrl_t;
endpackage

// File: rtl/ssp_rate_gen.sv
module ssp_rate_gen #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre16,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(15);
    localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(3);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] cnt;
    } rg_t;

    rg_t st_d, st_q;
    logic pre_last;

    assign pre_last = (st_q.pre == (pre16 ? LAST_SLOW : LAST_FAST));
    assign tick     = pre_last && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.pre = '0;
            st_d.cnt = reload;
        end else if (pre_last) begin
            st_d.pre = '0;
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssp_edge_det.sv
module ssp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } ed_t;

    ed_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    assign rise = st_q.s2 & ~st_q.s3;
    assign fall = ~st_q.s2 & st_q.s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave,
    input  logic              shift_en,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              sdi,
    input  logic              tick,
    input  logic              ext_rise,
    input  logic              ext_fall,
    output logic              sdo,
    output logic              sck,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] shreg
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              sck;
        logic              half;
        logic              busy;
        logic              sdo;
        logic              done;
    } sh_t;

    sh_t st_d, st_q;
    logic do_fall, do_rise;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        do_fall   = 1'b0;
        do_rise   = 1'b0;
        if (load) begin
            st_d.sr   = load_data;
            st_d.cnt  = '0;
            st_d.sck  = 1'b1;
            st_d.half = 1'b0;
            st_d.busy = !slave;
        end else if (!slave) begin
            if (st_q.busy && tick) begin
                st_d.half = ~st_q.half;
                if (st_q.half) begin
                    st_d.sck = ~st_q.sck;
                    do_fall  = st_q.sck;
                    do_rise  = !st_q.sck;
                end
            end
        end else if (shift_en) begin
            do_fall = ext_fall;
            do_rise = ext_rise;
        end
        if (do_fall) st_d.sdo = st_q.sr[0];
        if (do_rise) begin
            st_d.sr  = {sdi, st_q.sr[BYTE_W-1:1]};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) begin
                st_d.done = 1'b1;
                st_d.busy = 1'b0;
            end
        end
    end

    assign sdo   = st_q.sdo;
    assign sck   = st_q.sck;
    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign shreg = st_q.sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sck  <= 1'b1;
            st_q.sdo  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        sdo,
    input  logic        sdi,
    input  logic        sck_in,
    output logic        sck_out,
    output logic        sck_oe
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        ssp_ctrl_t         ctrl;
        logic [DIV_W-1:0]  reload;
        logic [BYTE_W-1:0] rxbuf;
        logic              flag;
    } regs_t;

    regs_t r_d, r_q;

    logic              brg_tick, ext_rise, ext_fall, start;
    logic              eng_sck, eng_busy, eng_done;
    logic [BYTE_W-1:0] eng_sr;
    logic              flag_q;

    assign start = wr_en && (addr == A_DATA) && r_q.ctrl.send_en
                   && !(eng_busy && !r_q.ctrl.slave);

    ssp_rate_gen #(.DIV_W(DIV_W), .PRE_W(4)) u_rate (
        .clk(clk), .rst_n(rst_n), .restart(start), .pre16(r_q.ctrl.pre16),
        .reload(r_q.reload), .tick(brg_tick)
    );

    ssp_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .pin(sck_in), .rise(ext_rise), .fall(ext_fall)
    );

    ssp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .slave(r_q.ctrl.slave), .shift_en(r_q.ctrl.send_en),
        .load(start), .load_data(wdata), .sdi(sdi), .tick(brg_tick),
        .ext_rise(ext_rise), .ext_fall(ext_fall), .sdo(sdo), .sck(eng_sck),
        .busy(eng_busy), .done(eng_done), .shreg(eng_sr)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == A_CTRL) r_d.ctrl   = wdata[2:0];
        if (wr_en && addr == A_DIV)  r_d.reload = wdata[DIV_W-1:0];
        if (rd_en && addr == A_DATA) r_d.flag   = 1'b0;
        if (eng_done) begin
            r_d.flag  = 1'b1;
            r_d.rxbuf = eng_sr;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {r_q.flag, eng_busy, 3'b000, r_q.ctrl};
            A_DIV:   rdata = 8'(r_q.reload);
            A_DATA:  rdata = r_q.rxbuf;
            default: rdata = 8'h00;
        endcase
    end

    assign sck_out = eng_sck;
    assign sck_oe  = !r_q.ctrl.slave;
    assign flag_q  = r_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic busy,
    input logic tick,
    input logic done_pulse,
    input logic flag
);
    // R2
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    // R3
    sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> $past(tick));

    // R5
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(done_pulse));

    // R5
    frame_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> flag);
endmodule

bind sync_serial_port ssp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sck(eng_sck), .busy(eng_busy),
    .tick(brg_tick), .done_pulse(eng_done), .flag(flag_q)
);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {pre16, n[7:0], tx[7:0], rx[7:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 8'd0, 8'hA5, 8'h3C},
        {1'b0, 8'd1, 8'h01, 8'h80},
        {1'b1, 8'd0, 8'hFF, 8'h00},
        {1'b0, 8'd3, 8'h5A, 8'hC3},
        {1'b1, 8'd2, 8'h80, 8'h7E},
        {1'b0, 8'd0, 8'h00, 8'hFF}
    };

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, sdi = 1, sck_in = 1;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic sdo, sck_out, sck_oe;
    int checks = 0, fails = 0, cyc = 0;

    sync_serial_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sdo(sdo), .sdi(sdi), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic run_master(input logic pre, input logic [7:0] n,
                              input logic [7:0] tx, input logic [7:0] rx);
        int half, falls, rises, tlow, bad_w, limit;
        logic prev;
        logic [7:0] cap, v;
        half = 2 * (pre ? 16 : 4) * (int'(n) + 1);
        falls = 0; rises = 0; bad_w = 0; cap = 0; tlow = 0;
        wr(2'd1, n);
        wr(2'd0, {5'b0, 1'b1, 1'b0, pre});
        wr(2'd2, tx);
        prev = sck_out;
        limit = 20 * half + 40;
        for (int t = 0; t < limit; t++) begin
            @(negedge clk);
            if (prev && !sck_out) begin
                falls++; tlow = cyc;
                if (falls <= 8) sdi = rx[falls-1];
            end else if (!prev && sck_out) begin
                if (rises < 8) cap[rises] = sdo;
                rises++;
                if (cyc - tlow != half) bad_w++;
            end
            prev = sck_out;
        end
        // R2: exactly eight pulses, clock parked high
        chk(falls == 8 && sck_out, "R2", falls, 8);
        // R3: low width 2*P*(n+1)
        chk(bad_w == 0, "R3", bad_w, 0);
        // R4: LSB-first output
        chk(cap == tx, "R4", cap, tx);
        rd(2'd0, v);
        // R5: complete flag
        chk(v[7] == 1'b1, "R5 flag", v[7], 1);
        rd(2'd2, v);
        // R5: received byte
        chk(v == rx, "R5 data", v, rx);
        rd(2'd0, v);
        // R6: read clears flag
        chk(v[7] == 1'b0, "R6", v[7], 0);
    endtask

    task automatic ext_byte(input logic [7:0] rx, output logic [7:0] cap);
        cap = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_in = 0; sdi = rx[i];
            repeat (10) @(negedge clk);
            cap[i] = sdo;
            sck_in = 1;
            repeat (10) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v, cap;
        int falls;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(2'd0, v);
        // R1: reset state
        chk(v == 8'h00 && sck_out && sck_oe && sdo, "R1", {sck_out, sck_oe, v}, 10'h300);

        for (int k = 0; k < NVEC; k++)
            run_master(VEC[k][24], VEC[k][23:16], VEC[k][15:8], VEC[k][7:0]);

        // R7: write with send enable cleared
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h55);
        falls = 0; prev = sck_out;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (prev && !sck_out) falls++;
            prev = sck_out;
        end
        rd(2'd0, v);
        chk(falls == 0 && v[7] == 1'b0, "R7", falls, 0);

        // R8: slave mode
        wr(2'd0, 8'h06);
        #1 chk(sck_oe == 1'b0, "R8 oe", sck_oe, 0);
        wr(2'd2, 8'hC6);
        ext_byte(8'h9B, cap);
        chk(cap == 8'hC6, "R8 sdo", cap, 8'hC6);
        rd(2'd0, v);
        chk(v[7] == 1'b1, "R8 flag", v[7], 1);
        rd(2'd2, v);
        chk(v == 8'h9B, "R8 data", v, 8'h9B);
        chk(sck_out == 1'b1, "R8 sck idle", sck_out, 1);

        // R9: continues into a second group of eight
        ext_byte(8'h2D, cap);
        chk(cap == 8'h9B, "R9 sdo", cap, 8'h9B);
        rd(2'd0, v);
        chk(v[7] == 1'b1, "R9 flag", v[7], 1);
        rd(2'd2, v);
        chk(v == 8'h2D, "R9 data", v, 8'h2D);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule